// File: doc/BRIEF.md
# Dual-Loop Status Pin Selector

This block turns the mode bits latched for two phase-locked loops into the value of one shared status pin. The pin can show nothing, the lock state of either loop or of both, a reference-divider or feedback-divider output of either loop, a fastlock damping switch, or a counter-reset state. The block also filters each loop's phase-error pulses into a lock flag.

The block also orders powerdown. A powerdown request for a loop takes effect only once that loop's charge pump is tri-stated. This keeps the loop from jumping in frequency as it shuts down. The shared reference oscillator and reference counter are turned off only when both loops are down.

Loop 1 uses index 0 of every two-bit port, and loop 2 uses index 1. All outputs are registered, and reset is synchronous and active high.

Top module: `dpll_aux_out`

## Requirements
- R1: While `rst` is high, and in the first sample after it, `fold_out`, `locked`, `cnt_reset`, `pdn_eff` and `osc_off` are all 0.
- R2: For each loop, the width of a reference cycle is the number of clocks with `perr` high, counted from the clock after the previous `ref_tick` up to and including the clock of the current `ref_tick`. A cycle is good when its width is below LOCK_WIN (4). `locked` rises on the edge that samples the LOCK_RUNS-th (4th) consecutive good `ref_tick`. It falls on the edge that samples any bad one.
- R3: The mode code uses hi = {`fsel_hi[1]`,`fsel_hi[0]`} and lo = {`fsel_lo[1]`,`fsel_lo[0]`}. With hi=00 and lo=10, the pin follows `locked[1] & ~perr[1]`. With hi=00 and lo=01, it follows `locked[0] & ~perr[0]`.
- R4: With hi=00 and lo=11, the pin is high only when both loops are locked and neither `perr` is high.
- R5: With hi=10, the pin shows `rdiv_out[1]` when `fsel_lo[1]`=0 and `ndiv_out[1]` otherwise. With hi=01, it shows `rdiv_out[0]` when `fsel_lo[0]`=0 and `ndiv_out[0]` otherwise.
- R6: The code hi=00 with lo=00 (disabled) drives the pin low. So do the reserved codes hi=11 with lo=01 or lo=10.
- R7: With hi=11 and lo=00 (fastlock), the pin is low while either `icp_hi` bit is high, and high otherwise.
- R8: With hi=11 and lo=11, `cnt_reset` is high and the pin is low. `cnt_reset` is low under every other code.
- R9: The pin and `cnt_reset` take the value selected by the inputs sampled at one rising edge, and hold it until the next edge.
- R10: `pdn_eff[i]` sets only on an edge where both `pdn_req[i]` and `cp_tristate[i]` are high. It then stays set while `pdn_req[i]` stays high, and clears on the first edge that samples `pdn_req[i]` low.
- R11: `osc_off` is high exactly when both `pdn_eff` bits are high.
- R12: While `pdn_eff[i]` is high, the lock filter of loop i is held cleared, so `locked[i]` is 0 from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 2 | One-clock pulse at the end of each reference cycle, per loop |
| perr | input | 2 | Phase-error pulse level, per loop |
| rdiv_out | input | 2 | Reference-divider output level, per loop |
| ndiv_out | input | 2 | Feedback-divider output level, per loop |
| cp_tristate | input | 2 | Charge pump currently tri-stated, per loop |
| fsel_lo | input | 2 | Low pin-mode select bit of each loop's reference word |
| fsel_hi | input | 2 | High pin-mode select bit of each loop's reference word |
| icp_hi | input | 2 | Charge-pump high-current bit, per loop |
| pdn_req | input | 2 | Loaded powerdown bit, per loop |
| fold_out | output | 1 | Registered shared status pin value |
| locked | output | 2 | Filtered lock flag, per loop |
| cnt_reset | output | 1 | Counter-reset hold strobe |
| pdn_eff | output | 2 | Effective powerdown, per loop |
| osc_off | output | 1 | Oscillator and reference counter disabled |

## Verification
Two pairs of functions can act on the same edge.

The first pair is powerdown and lock. A powerdown can take effect on the very edge where a loop's fourth good reference cycle would declare lock. The bench provokes this by keeping a loop's phase error clean while raising `pdn_req` with a sparse, random `cp_tristate`. The reference model then expects the clearing (R12) to win from the next edge on, and the lock filter to restart only after the request drops.

The second pair is a lock-mode pin and a phase-error pulse. The pin is checked on every clock in each lock-flavoured mode while loops gain and lose lock under noisy pulse widths. So the narrow low pulses and the lock transitions are judged against the model in the same registered cycle.

// File: rtl/dpll_aux_pkg.sv
package dpll_aux_pkg;

    // Function routed to the shared status pin
    typedef enum logic [3:0] {
        FM_OFF,
        FM_LOCK2,
        FM_LOCK1,
        FM_LOCK_BOTH,
        FM_RDIV2,
        FM_NDIV2,
        FM_RDIV1,
        FM_NDIV1,
        FM_FAST,
        FM_RSVD,
        FM_CRST
    } fold_mode_e;

    // Four select bits gathered from both reference words
    typedef struct packed {
        logic hi2;
        logic hi1;
        logic lo2;
        logic lo1;
    } mode_bits_t;

    function automatic fold_mode_e decode_mode(mode_bits_t m);
        fold_mode_e r;
        case ({m.hi2, m.hi1})
            2'b00: begin
                case ({m.lo2, m.lo1})
                    2'b00:   r = FM_OFF;
                    2'b10:   r = FM_LOCK2;
                    2'b01:   r = FM_LOCK1;
                    default: r = FM_LOCK_BOTH;
                endcase
            end
            2'b10:   r = m.lo2 ? FM_NDIV2 : FM_RDIV2;
            2'b01:   r = m.lo1 ? FM_NDIV1 : FM_RDIV1;
            default: begin
                case ({m.lo2, m.lo1})
                    2'b00:   r = FM_FAST;
                    2'b11:   r = FM_CRST;
                    default: r = FM_RSVD;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dpll_lock_filter.sv
module dpll_lock_filter #(
    parameter int LOCK_WIN  = 4,
    parameter int LOCK_RUNS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_clr,
    input  logic ref_tick,
    input  logic perr,
    output logic locked
);
    localparam int WID_W = $clog2(LOCK_WIN + 1);
    localparam int RUN_W = $clog2(LOCK_RUNS + 1);
    localparam logic [WID_W-1:0] WID_MAX  = WID_W'(LOCK_WIN);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_RUNS);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUNS - 1);

    logic [WID_W-1:0] wid_q, wid_now;
    logic [RUN_W-1:0] run_q;
    logic             lock_q;
    logic             good;

    // Saturating width of the current reference cycle, this clock included
    always_comb begin
        wid_now = wid_q;
        if (perr && (wid_q != WID_MAX)) wid_now = wid_q + 1'b1;
    end

    assign good = (wid_now != WID_MAX);

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            wid_q  <= '0;
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (ref_tick) begin
            wid_q <= '0;
            if (good) begin
                if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
                if (run_q == RUN_LAST) lock_q <= 1'b1;
            end else begin
                run_q  <= '0;
                lock_q <= 1'b0;
            end
        end else begin
            wid_q <= wid_now;
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/dpll_pdn_seq.sv
module dpll_pdn_seq #(
    parameter int NLOOP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLOOP-1:0] pdn_req,
    input  logic [NLOOP-1:0] cp_tristate,
    output logic [NLOOP-1:0] pdn_eff,
    output logic             osc_off
);
    logic [NLOOP-1:0] eff_q;

    for (genvar g = 0; g < NLOOP; g++) begin : g_loop
        // Enter only at a tri-state moment, leave as soon as the request drops
        always_ff @(posedge clk) begin
            if (rst) eff_q[g] <= 1'b0;
            else     eff_q[g] <= pdn_req[g] & (eff_q[g] | cp_tristate[g]);
        end
    end

    assign pdn_eff = eff_q;
    assign osc_off = &eff_q;
endmodule

// File: rtl/dpll_fold_select.sv
module dpll_fold_select
    import dpll_aux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fold_mode_e mode,
    input  logic [1:0] locked,
    input  logic [1:0] perr,
    input  logic [1:0] rdiv,
    input  logic [1:0] ndiv,
    input  logic [1:0] icp_hi,
    output logic       fold_out,
    output logic       cnt_reset
);
    logic fold_d;
    logic crst_d;

    always_comb begin
        fold_d = 1'b0;
        crst_d = 1'b0;
        case (mode)
            FM_LOCK2:     fold_d = locked[1] & ~perr[1];
            FM_LOCK1:     fold_d = locked[0] & ~perr[0];
            FM_LOCK_BOTH: fold_d = &locked & ~(|perr);
            FM_RDIV2:     fold_d = rdiv[1];
            FM_NDIV2:     fold_d = ndiv[1];
            FM_RDIV1:     fold_d = rdiv[0];
            FM_NDIV1:     fold_d = ndiv[0];
            FM_FAST:      fold_d = ~(|icp_hi);
            FM_CRST:      crst_d = 1'b1;
            default:      fold_d = 1'b0;
        endcase
    end

    // Registered pin: mode changes cannot glitch the output
    always_ff @(posedge clk) begin
        if (rst) begin
            fold_out  <= 1'b0;
            cnt_reset <= 1'b0;
        end else begin
            fold_out  <= fold_d;
            cnt_reset <= crst_d;
        end
    end
endmodule

// File: rtl/dpll_aux_out.sv
module dpll_aux_out
    import dpll_aux_pkg::*;
#(
    parameter int LOCK_WIN  = 4,
    parameter int LOCK_RUNS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ref_tick,
    input  logic [1:0] perr,
    input  logic [1:0] rdiv_out,
    input  logic [1:0] ndiv_out,
    input  logic [1:0] cp_tristate,
    input  logic [1:0] fsel_lo,
    input  logic [1:0] fsel_hi,
    input  logic [1:0] icp_hi,
    input  logic [1:0] pdn_req,
    output logic       fold_out,
    output logic [1:0] locked,
    output logic       cnt_reset,
    output logic [1:0] pdn_eff,
    output logic       osc_off
);
    localparam int NLOOP = 2;

    mode_bits_t mbits;
    fold_mode_e mode;
    logic [NLOOP-1:0] eff;

    assign mbits = '{hi2: fsel_hi[1], hi1: fsel_hi[0], lo2: fsel_lo[1], lo1: fsel_lo[0]};
    assign mode  = decode_mode(mbits);

    dpll_pdn_seq #(.NLOOP(NLOOP)) i_pdn (
        .clk         (clk),
        .rst         (rst),
        .pdn_req     (pdn_req),
        .cp_tristate (cp_tristate),
        .pdn_eff     (eff),
        .osc_off     (osc_off)
    );

    for (genvar g = 0; g < NLOOP; g++) begin : g_lock
        dpll_lock_filter #(.LOCK_WIN(LOCK_WIN), .LOCK_RUNS(LOCK_RUNS)) i_flt (
            .clk      (clk),
            .rst      (rst),
            .hold_clr (eff[g]),
            .ref_tick (ref_tick[g]),
            .perr     (perr[g]),
            .locked   (locked[g])
        );
    end

    dpll_fold_select i_sel (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .locked    (locked),
        .perr      (perr),
        .rdiv      (rdiv_out),
        .ndiv      (ndiv_out),
        .icp_hi    (icp_hi),
        .fold_out  (fold_out),
        .cnt_reset (cnt_reset)
    );

    assign pdn_eff = eff;
endmodule

// File: rtl/dpll_aux_out_chk.sv
module dpll_aux_out_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ref_tick,
    input logic [1:0] cp_tristate,
    input logic [1:0] fsel_lo,
    input logic [1:0] fsel_hi,
    input logic [1:0] icp_hi,
    input logic [1:0] pdn_req,
    input logic       fold_out,
    input logic [1:0] locked,
    input logic       cnt_reset,
    input logic [1:0] pdn_eff,
    input logic       osc_off
);
    logic c_off, c_fast, c_crst;
    assign c_off  = (fsel_hi == 2'b00 && fsel_lo == 2'b00) ||
                    (fsel_hi == 2'b11 && (fsel_lo == 2'b01 || fsel_lo == 2'b10));
    assign c_fast = (fsel_hi == 2'b11 && fsel_lo == 2'b00);
    assign c_crst = (fsel_hi == 2'b11 && fsel_lo == 2'b11);

    p_off_low_r6: assert property (@(posedge clk) disable iff (rst) c_off |=> !fold_out);
    p_crst_hold_r8: assert property (@(posedge clk) disable iff (rst) c_crst |=> (cnt_reset && !fold_out));
    p_crst_only_r8: assert property (@(posedge clk) disable iff (rst) !c_crst |=> !cnt_reset);
    p_fast_pull_r7: assert property (@(posedge clk) disable iff (rst) (c_fast && |icp_hi) |=> !fold_out);
    p_pdn_wait0_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pdn_eff[0]) |-> $past(cp_tristate[0] && pdn_req[0]));
    p_pdn_wait1_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pdn_eff[1]) |-> $past(cp_tristate[1] && pdn_req[1]));
    p_osc_both_r11: assert property (@(posedge clk) disable iff (rst) osc_off |-> (pdn_eff == 2'b11));
    p_lock_tick0_r2: assert property (@(posedge clk) disable iff (rst) $rose(locked[0]) |-> $past(ref_tick[0]));
    p_lock_tick1_r2: assert property (@(posedge clk) disable iff (rst) $rose(locked[1]) |-> $past(ref_tick[1]));
    p_pdn_clear0_r12: assert property (@(posedge clk) disable iff (rst) pdn_eff[0] |=> !locked[0]);
    p_pdn_clear1_r12: assert property (@(posedge clk) disable iff (rst) pdn_eff[1] |=> !locked[1]);
endmodule

bind dpll_aux_out dpll_aux_out_chk i_chk (.*);

// File: tb/test_dpll_aux_out.sv
module test_dpll_aux_out;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 4;
    localparam int RUNS = 4;
    localparam int PER0 = 8;
    localparam int PER1 = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] ref_tick = '0, perr = '0, rdiv_out = '0, ndiv_out = '0, cp_tristate = '0;
    logic [1:0] fsel_lo = '0, fsel_hi = '0, icp_hi = '0, pdn_req = '0;
    logic       fold_out, cnt_reset, osc_off;
    logic [1:0] locked, pdn_eff;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_aux_out #(.LOCK_WIN(WIN), .LOCK_RUNS(RUNS)) i_dpll_aux_out (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .perr(perr), .rdiv_out(rdiv_out),
        .ndiv_out(ndiv_out), .cp_tristate(cp_tristate), .fsel_lo(fsel_lo), .fsel_hi(fsel_hi),
        .icp_hi(icp_hi), .pdn_req(pdn_req), .fold_out(fold_out), .locked(locked),
        .cnt_reset(cnt_reset), .pdn_eff(pdn_eff), .osc_off(osc_off)
    );

    int checks = 0;
    int fails  = 0;

    // Requested stimulus, applied by step() just after the falling edge
    logic [1:0] q_lo = '0, q_hi = '0, q_icp = '0, q_pdn = '0;
    logic       q_rst = 1'b1;
    int noisy = 0;
    int tri_pct = 50;

    // Reference model state
    int m_wid[2] = '{0, 0};
    int m_run[2] = '{0, 0};
    bit m_lk[2]  = '{0, 0};
    bit m_pe[2]  = '{0, 0};
    bit m_fold = 0, m_crst = 0, m_rst = 1;
    string m_tag = "R1";
    int ph[2] = '{0, 0};
    int wd[2] = '{0, 0};

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit lk_old[2];
        bit pe_old[2];
        bit f;
        lk_old = m_lk;
        pe_old = m_pe;
        m_rst = rst;
        if (rst) begin
            m_wid = '{0, 0}; m_run = '{0, 0}; m_lk = '{0, 0}; m_pe = '{0, 0};
            m_fold = 0; m_crst = 0; m_tag = "R1";
            return;
        end
        // Pin value from the inputs of this edge and the lock flags before it (R9)
        f = 0;
        m_crst = 0;
        if (fsel_hi == 2'b00) begin
            if (fsel_lo == 2'b00) begin f = 0; m_tag = "R6"; end
            else if (fsel_lo == 2'b10) begin f = lk_old[1] && !perr[1]; m_tag = "R3"; end
            else if (fsel_lo == 2'b01) begin f = lk_old[0] && !perr[0]; m_tag = "R3"; end
            else begin f = lk_old[0] && lk_old[1] && perr == 2'b00; m_tag = "R4"; end
        end else if (fsel_hi == 2'b10) begin
            f = fsel_lo[1] ? ndiv_out[1] : rdiv_out[1]; m_tag = "R5";
        end else if (fsel_hi == 2'b01) begin
            f = fsel_lo[0] ? ndiv_out[0] : rdiv_out[0]; m_tag = "R5";
        end else begin
            if (fsel_lo == 2'b00) begin f = (icp_hi == 2'b00); m_tag = "R7"; end
            else if (fsel_lo == 2'b11) begin f = 0; m_crst = 1; m_tag = "R8"; end
            else begin f = 0; m_tag = "R6"; end
        end
        m_fold = f;
        for (int i = 0; i < 2; i++) begin
            int w;
            w = m_wid[i] + (perr[i] ? 1 : 0);
            if (w > WIN) w = WIN;
            if (pe_old[i]) begin            // R12 hold
                m_wid[i] = 0; m_run[i] = 0; m_lk[i] = 0;
            end else if (ref_tick[i]) begin // R2
                m_wid[i] = 0;
                if (w < WIN) begin
                    m_run[i] = (m_run[i] + 1 > RUNS) ? RUNS : m_run[i] + 1;
                    m_lk[i]  = (m_run[i] >= RUNS);
                end else begin
                    m_run[i] = 0; m_lk[i] = 0;
                end
            end else begin
                m_wid[i] = w;
            end
            m_pe[i] = pdn_req[i] && (pe_old[i] || cp_tristate[i]); // R10
        end
    endtask

    task automatic step();
        @(negedge clk);
        // Outputs now reflect the last rising edge (R9: one registered stage)
        chk(m_rst ? "R1" : m_tag, "fold_out", int'(fold_out), int'(m_fold));
        chk(m_rst ? "R1" : "R2 R12", "locked[0]", int'(locked[0]), int'(m_lk[0]));
        chk(m_rst ? "R1" : "R2 R12", "locked[1]", int'(locked[1]), int'(m_lk[1]));
        chk(m_rst ? "R1" : "R8", "cnt_reset", int'(cnt_reset), int'(m_crst));
        chk(m_rst ? "R1" : "R10", "pdn_eff[0]", int'(pdn_eff[0]), int'(m_pe[0]));
        chk(m_rst ? "R1" : "R10", "pdn_eff[1]", int'(pdn_eff[1]), int'(m_pe[1]));
        chk(m_rst ? "R1" : "R11", "osc_off", int'(osc_off), int'(m_pe[0] && m_pe[1]));
        // Drive the next cycle
        rst = q_rst; fsel_lo = q_lo; fsel_hi = q_hi; icp_hi = q_icp; pdn_req = q_pdn;
        for (int i = 0; i < 2; i++) begin
            int per;
            per = (i == 0) ? PER0 : PER1;
            if (ph[i] == 0) wd[i] = (int'($urandom % 100) < noisy) ? 6 : int'($urandom % 3);
            ref_tick[i] = (ph[i] == per - 1);
            perr[i]     = (ph[i] < wd[i]);
            ph[i]       = (ph[i] + 1) % per;
            cp_tristate[i] = (int'($urandom % 100) < tri_pct);
        end
        rdiv_out = 2'($urandom);
        ndiv_out = 2'($urandom);
        model_update();
    endtask

    task automatic set_mode(logic [1:0] hi, logic [1:0] lo);
        q_hi = hi; q_lo = lo;
    endtask

    initial begin
        repeat (4) step();                 // R1 reset state checked here
        q_rst = 1'b0;
        set_mode(2'b00, 2'b01); noisy = 0;  repeat (60) step();   // R3 lock on loop 1
        noisy = 30; repeat (80) step();                           // R2 loss of lock
        set_mode(2'b00, 2'b10); noisy = 10; repeat (80) step();   // R3 loop 2
        set_mode(2'b00, 2'b11); repeat (100) step();              // R4 combined
        set_mode(2'b10, 2'b00); repeat (30) step();               // R5
        set_mode(2'b10, 2'b10); repeat (30) step();
        set_mode(2'b01, 2'b00); repeat (30) step();
        set_mode(2'b01, 2'b01); repeat (30) step();
        set_mode(2'b11, 2'b00);                                   // R7 fastlock
        for (int k = 0; k < 40; k++) begin q_icp = 2'(k % 4); step(); end
        q_icp = '0;
        set_mode(2'b11, 2'b01); repeat (15) step();               // R6 reserved
        set_mode(2'b11, 2'b10); repeat (15) step();
        set_mode(2'b00, 2'b00); repeat (15) step();               // R6 disabled
        set_mode(2'b11, 2'b11); repeat (20) step();               // R8 counter reset
        // R10 R11 R12 powerdown sequencing against a sparse tri-state
        set_mode(2'b00, 2'b11); noisy = 0; tri_pct = 10; repeat (60) step();
        q_pdn = 2'b01; repeat (60) step();
        q_pdn = 2'b11; repeat (60) step();
        q_pdn = 2'b10; repeat (60) step();
        q_pdn = 2'b00; repeat (80) step();
        // Mixed traffic
        for (int k = 0; k < 150; k++) begin
            set_mode(2'($urandom), 2'($urandom));
            q_icp   = 2'($urandom);
            q_pdn   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            noisy   = int'($urandom % 40);
            tri_pct = int'($urandom % 60);
            repeat (15) step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL all-requirements watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule